// File: doc/BRIEF.md
# Two-Channel PWM Action Qualifier with Software Force

This block turns the state of a shared time-base counter into two PWM pin levels. A time-base block elsewhere supplies the counter value, a counter-at-zero strobe, a counter-at-period strobe, a count-direction flag and a tick enable. Each channel owns a 16-bit compare value and an action word. The action word says what the pin does when the counter is at zero, at period, or passes either compare value while counting up. Each action can leave the pin alone, drive it low, drive it high or toggle it.

A continuous software force can hold either pin low or high regardless of the events. Writes to the force register go to a shadow copy. The active copy is loaded from the shadow at a selectable point: counter zero, counter period, either of those, or the next tick. Typical settings are these. For a normal-polarity waveform, set the pin high at zero and at period and low on the compare-up match. For inverted polarity, use the opposite levels. To stop a channel cleanly, select immediate reload and force the pin low.

Top module: `pwm_aq`

## Requirements
- R1: After synchronous reset both pins are low, every action word and compare value is zero, the shadow and active force codes are 00 and the reload mode is 00.
- R2: Each 2-bit action field is decoded as 00 no change, 01 drive low, 10 drive high, 11 toggle. It is applied only when its event occurs.
- R3: The register write port uses address 0 for the channel A action word, 1 for the channel B action word, 2 for compare A and 3 for compare B. In each action word, bits 1:0 act on counter zero, bits 3:2 on counter period, bits 5:4 on a compare-A match while counting up and bits 9:8 on a compare-B match while counting up.
- R4: A compare match counts as an event only while the direction flag is 1 (counting up). A counter equal to a compare value while counting down has no effect.
- R5: When several events fall on one tick, the winner is the highest-priority event whose field is not 00. The order from highest to lowest is compare B, compare A, period, zero.
- R6: Events act only on clock edges where the tick input is 1. With tick at 0, neither the pins nor the active force change.
- R7: The force shadow is written at address 4, with channel A at bits 1:0 and channel B at bits 3:2. Code 01 forces low, 10 forces high, and 00 or 11 releases the pin to event control. An active force overrides every event action.
- R8: The reload mode is written at bits 7:6 of address 5. Mode 00 loads the active force from the shadow on a zero tick, 01 on a period tick, 10 on either, and 11 on the next tick. Until that load, a shadow write has no effect on the pins.
- R9: Action word 0x1A on channel A and 0x205 on channel B, with equal compare values, give complementary normal and inverted waveforms.
- R10: A pin changes at the clock edge that takes the event tick, never combinationally from the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Time-base tick enable; events and force reloads act only when 1 |
| cnt | input | CNT_W | Shared time-base counter value |
| zero_evt | input | 1 | Counter-at-zero strobe |
| prd_evt | input | 1 | Counter-at-period strobe |
| dir_up | input | 1 | 1 while the counter counts up |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0..5) |
| wr_data | input | CNT_W | Register write data |
| pwm_a | output | 1 | Channel A pin |
| pwm_b | output | 1 | Channel B pin |

## Verification
Every combination of the zero, period and compare codes on both channels is swept. The compare value is placed at zero, mid-period and at the period, so that every event coincidence and every priority outcome is observed. An up-down counter run separates matches taken while counting up from matches that must be ignored on the way down. Each reload mode is stepped through a non-event tick, a period tick and a zero tick, which shows exactly when the shadow force takes control. Held-off ticks and a pre-edge sample show that the pins move only on tick edges.

// File: rtl/pwm_aq_pkg.sv
package pwm_aq_pkg;

    localparam int NCH    = 2;
    localparam int ADDR_W = 3;

    // register addresses
    localparam int ADR_ACT_BASE = 0;
    localparam int ADR_CMP_BASE = 2;
    localparam int ADR_FRC      = 4;
    localparam int ADR_RLD      = 5;

    // field positions that software decodes
    localparam int ZERO_LSB = 0;
    localparam int PRD_LSB  = 2;
    localparam int CMPA_LSB = 4;
    localparam int CMPB_LSB = 8;
    localparam int FRC_LSB  = 0;
    localparam int FRC_STEP = 2;
    localparam int RLD_LSB  = 6;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'b00,
        ACT_LOW    = 2'b01,
        ACT_HIGH   = 2'b10,
        ACT_TOGGLE = 2'b11
    } act_e;

    typedef enum logic [1:0] {
        FRC_OFF  = 2'b00,
        FRC_LOW  = 2'b01,
        FRC_HIGH = 2'b10,
        FRC_DIS  = 2'b11
    } frc_e;

    typedef enum logic [1:0] {
        RLD_ZERO   = 2'b00,
        RLD_PRD    = 2'b01,
        RLD_EITHER = 2'b10,
        RLD_IMM    = 2'b11
    } rld_e;

    typedef struct packed {
        act_e cmp_b;
        act_e cmp_a;
        act_e prd;
        act_e zero;
    } evt_act_t;

    typedef struct packed {
        logic cmp_b;
        logic cmp_a;
        logic prd;
        logic zero;
    } evt_t;

    // highest-priority event that has a real action
    function automatic act_e pick_act(evt_t ev, evt_act_t cfg);
        act_e a;
        a = ACT_NONE;
        if (ev.zero  && cfg.zero  != ACT_NONE) a = cfg.zero;
        if (ev.prd   && cfg.prd   != ACT_NONE) a = cfg.prd;
        if (ev.cmp_a && cfg.cmp_a != ACT_NONE) a = cfg.cmp_a;
        if (ev.cmp_b && cfg.cmp_b != ACT_NONE) a = cfg.cmp_b;
        return a;
    endfunction

    function automatic logic apply_act(act_e a, logic cur);
        case (a)
            ACT_LOW:    return 1'b0;
            ACT_HIGH:   return 1'b1;
            ACT_TOGGLE: return ~cur;
            default:    return cur;
        endcase
    endfunction

endpackage

// File: rtl/pwm_aq_regs.sv
module pwm_aq_regs
    import pwm_aq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [CNT_W-1:0]    wr_data,
    output evt_act_t            act_cfg [NCH],
    output logic [CNT_W-1:0]    cmp_val [NCH],
    output frc_e                frc_sh  [NCH],
    output rld_e                rld_mode
);

    localparam logic [ADDR_W-1:0] A_RLD = ADDR_W'(ADR_RLD);

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        localparam logic [ADDR_W-1:0] A_ACT = ADDR_W'(ADR_ACT_BASE + ch);
        localparam logic [ADDR_W-1:0] A_CMP = ADDR_W'(ADR_CMP_BASE + ch);
        localparam logic [ADDR_W-1:0] A_FRC = ADDR_W'(ADR_FRC);
        localparam int FLSB = FRC_LSB + FRC_STEP * ch;

        always_ff @(posedge clk) begin
            if (rst) begin
                act_cfg[ch] <= '{ACT_NONE, ACT_NONE, ACT_NONE, ACT_NONE};
                cmp_val[ch] <= '0;
                frc_sh[ch]  <= FRC_OFF;
            end else if (wr_en) begin
                if (wr_addr == A_ACT) begin
                    act_cfg[ch].zero  <= act_e'(wr_data[ZERO_LSB +: 2]);
                    act_cfg[ch].prd   <= act_e'(wr_data[PRD_LSB  +: 2]);
                    act_cfg[ch].cmp_a <= act_e'(wr_data[CMPA_LSB +: 2]);
                    act_cfg[ch].cmp_b <= act_e'(wr_data[CMPB_LSB +: 2]);
                end
                if (wr_addr == A_CMP)
                    cmp_val[ch] <= wr_data;
                if (wr_addr == A_FRC)
                    frc_sh[ch] <= frc_e'(wr_data[FLSB +: 2]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rld_mode <= RLD_ZERO;
        else if (wr_en && wr_addr == A_RLD)
            rld_mode <= rld_e'(wr_data[RLD_LSB +: 2]);
    end

endmodule

// File: rtl/pwm_aq_events.sv
module pwm_aq_events
    import pwm_aq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             tick,
    input  logic [CNT_W-1:0] cnt,
    input  logic             zero_evt,
    input  logic             prd_evt,
    input  logic             dir_up,
    input  logic [CNT_W-1:0] cmp_val [NCH],
    output evt_t             evt
);

    // all events are qualified by the tick so later stages need not
    always_comb begin
        evt.zero  = tick & zero_evt;
        evt.prd   = tick & prd_evt;
        evt.cmp_a = tick & dir_up & (cnt == cmp_val[0]);
        evt.cmp_b = tick & dir_up & (cnt == cmp_val[1]);
    end

endmodule

// File: rtl/pwm_aq_force.sv
module pwm_aq_force
    import pwm_aq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  evt_t evt,
    input  frc_e frc_sh  [NCH],
    input  rld_e rld_mode,
    output frc_e frc_act [NCH],
    output frc_e frc_nxt [NCH]
);

    logic load;

    always_comb begin
        case (rld_mode)
            RLD_ZERO:   load = evt.zero;
            RLD_PRD:    load = evt.prd;
            RLD_EITHER: load = evt.zero | evt.prd;
            default:    load = tick;
        endcase
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        assign frc_nxt[ch] = load ? frc_sh[ch] : frc_act[ch];

        always_ff @(posedge clk) begin
            if (rst)
                frc_act[ch] <= FRC_OFF;
            else
                frc_act[ch] <= frc_nxt[ch];
        end
    end

endmodule

// File: rtl/pwm_aq_chan.sv
module pwm_aq_chan
    import pwm_aq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  evt_t     evt,
    input  evt_act_t cfg,
    input  frc_e     frc,
    output logic     pwm
);

    logic pwm_r;
    logic nxt;
    act_e act;

    always_comb begin
        act = pick_act(evt, cfg);
        nxt = apply_act(act, pwm_r);
        if (frc == FRC_LOW)
            nxt = 1'b0;
        else if (frc == FRC_HIGH)
            nxt = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            pwm_r <= 1'b0;
        else if (tick)
            pwm_r <= nxt;
    end

    assign pwm = pwm_r;

endmodule

// File: rtl/pwm_aq.sv
module pwm_aq
    import pwm_aq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              zero_evt,
    input  logic              prd_evt,
    input  logic              dir_up,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic              pwm_a,
    output logic              pwm_b
);

    evt_act_t         act_cfg [NCH];
    logic [CNT_W-1:0] cmp_val [NCH];
    frc_e             frc_sh  [NCH];
    frc_e             frc_act [NCH];
    frc_e             frc_nxt [NCH];
    rld_e             rld_mode;
    evt_t             evt;
    logic [NCH-1:0]   pwm_q;

    pwm_aq_regs #(.CNT_W(CNT_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .act_cfg  (act_cfg),
        .cmp_val  (cmp_val),
        .frc_sh   (frc_sh),
        .rld_mode (rld_mode)
    );

    pwm_aq_events #(.CNT_W(CNT_W)) u_evt (
        .tick     (tick),
        .cnt      (cnt),
        .zero_evt (zero_evt),
        .prd_evt  (prd_evt),
        .dir_up   (dir_up),
        .cmp_val  (cmp_val),
        .evt      (evt)
    );

    pwm_aq_force u_force (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .evt      (evt),
        .frc_sh   (frc_sh),
        .rld_mode (rld_mode),
        .frc_act  (frc_act),
        .frc_nxt  (frc_nxt)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        pwm_aq_chan u_chan (
            .clk  (clk),
            .rst  (rst),
            .tick (tick),
            .evt  (evt),
            .cfg  (act_cfg[ch]),
            .frc  (frc_nxt[ch]),
            .pwm  (pwm_q[ch])
        );
    end

    assign pwm_a = pwm_q[0];
    assign pwm_b = pwm_q[1];

endmodule

// File: rtl/pwm_aq_chk.sv
module pwm_aq_chk (
    input logic       clk,
    input logic       rst,
    input logic       tick,
    input logic       pwm_a,
    input logic       pwm_b,
    input logic [1:0] frc_a,
    input logic [1:0] frc_b
);

    p_hold_a_r6: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(pwm_a));

    p_hold_b_r6: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(pwm_b));

    p_force_low_a_r7: assert property (@(posedge clk) disable iff (rst)
        (frc_a == 2'b01) |-> !pwm_a);

    p_force_high_a_r7: assert property (@(posedge clk) disable iff (rst)
        (frc_a == 2'b10) |-> pwm_a);

    p_force_low_b_r7: assert property (@(posedge clk) disable iff (rst)
        (frc_b == 2'b01) |-> !pwm_b);

    p_force_high_b_r7: assert property (@(posedge clk) disable iff (rst)
        (frc_b == 2'b10) |-> pwm_b);

    p_force_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !tick |=> ($stable(frc_a) && $stable(frc_b)));

endmodule

bind pwm_aq pwm_aq_chk u_chk (
    .clk   (clk),
    .rst   (rst),
    .tick  (tick),
    .pwm_a (pwm_a),
    .pwm_b (pwm_b),
    .frc_a (frc_act[0]),
    .frc_b (frc_act[1])
);

// File: tb/pwm_aq_test.sv
`timescale 1ns/1ps
module pwm_aq_test;

    localparam int CNT_W = 16;
    localparam int P     = 5;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             tick = 1'b0;
    logic [CNT_W-1:0] cnt = '0;
    logic             zero_evt = 1'b0;
    logic             prd_evt = 1'b0;
    logic             dir_up = 1'b1;
    logic             wr_en = 1'b0;
    logic [2:0]       wr_addr = '0;
    logic [CNT_W-1:0] wr_data = '0;
    logic             pwm_a, pwm_b;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench model state
    logic [15:0] cfg_m [2];
    int          cmp_m [2];
    logic [1:0]  sh_m  [2];
    logic [1:0]  ac_m  [2];
    logic [1:0]  mode_m;
    bit          exp_m [2];

    always #2.5 clk = ~clk;

    pwm_aq #(.CNT_W(CNT_W)) uut (
        .clk(clk), .rst(rst), .tick(tick), .cnt(cnt),
        .zero_evt(zero_evt), .prd_evt(prd_evt), .dir_up(dir_up),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pwm_a(pwm_a), .pwm_b(pwm_b)
    );

    task automatic chk(input bit got, input bit exp, input string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0b expected %0b at %0t", what, got, exp, $time);
        end
    endtask

    function automatic bit evalc(logic [15:0] cfg, bit cur, bit z, bit p, bit ca, bit cb);
        logic [1:0] code = 2'b00;
        if (z  && cfg[1:0] != 0) code = cfg[1:0];
        if (p  && cfg[3:2] != 0) code = cfg[3:2];
        if (ca && cfg[5:4] != 0) code = cfg[5:4];
        if (cb && cfg[9:8] != 0) code = cfg[9:8];
        case (code)
            2'b01:   return 1'b0;
            2'b10:   return 1'b1;
            2'b11:   return ~cur;
            default: return cur;
        endcase
    endfunction

    task automatic wr(input int a, input int d);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = CNT_W'(d); tick = 1'b0;
        @(posedge clk); #1;
        wr_en = 1'b0;
        case (a)
            0, 1: cfg_m[a] = 16'(d);
            2, 3: cmp_m[a-2] = d;
            4: begin sh_m[0] = 2'(d); sh_m[1] = 2'(d >> 2); end
            5: mode_m = 2'(d >> 6);
            default: ;
        endcase
    endtask

    task automatic step(input int c, input bit z, input bit p, input bit up,
                        input bit tk, input string req);
        bit ld;
        cnt = CNT_W'(c); zero_evt = z; prd_evt = p; dir_up = up; tick = tk;
        @(posedge clk); #1;
        if (tk) begin
            case (mode_m)
                2'd0: ld = z;
                2'd1: ld = p;
                2'd2: ld = z | p;
                default: ld = 1'b1;
            endcase
            for (int ch = 0; ch < 2; ch++) begin
                bit r;
                if (ld) ac_m[ch] = sh_m[ch];
                r = evalc(cfg_m[ch], exp_m[ch], z, p,
                          up && c == cmp_m[0], up && c == cmp_m[1]);
                if (ac_m[ch] == 2'b01) r = 1'b0;
                if (ac_m[ch] == 2'b10) r = 1'b1;
                exp_m[ch] = r;
            end
        end
        chk(pwm_a, exp_m[0], {req, " pwm_a"});
        chk(pwm_b, exp_m[1], {req, " pwm_b"});
        tick = 1'b0; zero_evt = 1'b0; prd_evt = 1'b0;
    endtask

    task automatic run_up(input int n, input string req);
        for (int k = 0; k < n; k++)
            for (int c = 0; c <= P; c++)
                step(c, c == 0, c == P, 1'b1, 1'b1, req);
    endtask

    initial begin : wd
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got running expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        int hi_a, hi_b;
        for (int ch = 0; ch < 2; ch++) begin
            cfg_m[ch] = '0; cmp_m[ch] = 0; sh_m[ch] = '0; ac_m[ch] = '0; exp_m[ch] = 0;
        end
        mode_m = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state; no action configured so events do nothing
        chk(pwm_a, 1'b0, "R1 reset pwm_a");
        chk(pwm_b, 1'b0, "R1 reset pwm_b");
        run_up(1, "R1 idle after reset");

        // R2 R3 R5: sweep of zero/period/compare codes and compare positions
        for (int cp = 0; cp < 3; cp++) begin
            int cv;
            cv = (cp == 0) ? 0 : (cp == 1) ? 3 : P;
            wr(2, cv);
            wr(3, (cv + 1) % (P + 1));
            for (int code = 0; code < 64; code++) begin
                wr(0, code[5:0]);
                wr(1, {code[5:4], 4'b0000, code[3:0]});
                run_up(2, "R2/R3/R5 sweep");
            end
        end

        // R5: compare B outranks compare A on the same tick
        wr(2, 3); wr(3, 3);
        wr(0, 16'h0120);   // A: cmpA high, cmpB low
        wr(1, 16'h0210);   // B: cmpA low, cmpB high
        run_up(1, "R5 cmpB over cmpA");
        // R5: a 00 higher field lets the lower event act
        wr(2, P); wr(0, 16'h0008);
        run_up(1, "R5 none defers to period");

        // R4: up-down count, compare hit while counting down ignored
        wr(2, 3); wr(3, 2);
        wr(0, 16'h0030); wr(1, 16'h0300);
        for (int k = 0; k < 3; k++) begin
            for (int c = 0; c <= P; c++) step(c, c == 0, c == P, 1'b1, 1'b1, "R4 up");
            for (int c = P - 1; c >= 1; c--) step(c, 1'b0, 1'b0, 1'b0, 1'b1, "R4 down");
        end

        // R6: events without tick do nothing
        wr(0, 16'h0003); wr(1, 16'h000C);
        for (int k = 0; k < 4; k++) step(0, 1'b1, 1'b1, 1'b1, 1'b0, "R6 no tick");

        // R10: no combinational path, change lands on the tick edge
        wr(0, 16'h0001); step(0, 1'b1, 1'b0, 1'b1, 1'b1, "R10 prep");
        wr(0, 16'h0002);
        cnt = '0; zero_evt = 1'b1; tick = 1'b1; #1;
        chk(pwm_a, 1'b0, "R10 before edge");
        @(posedge clk); #1;
        exp_m[0] = 1'b1;
        chk(pwm_a, 1'b1, "R10 after edge");
        tick = 1'b0; zero_evt = 1'b0;

        // R7 R8: force in every reload mode, events driving the other way
        wr(2, 3); wr(3, 3);
        for (int m = 0; m < 4; m++) begin
            wr(0, 16'h0005);   // A low at zero and period
            wr(1, 16'h000A);   // B high at zero and period
            run_up(1, "R7 pre-force");
            wr(5, m << 6);
            wr(4, 6);          // A high, B low
            step(2, 1'b0, 1'b0, 1'b1, 1'b0, "R8 shadow only");
            step(2, 1'b0, 1'b0, 1'b1, 1'b1, "R8 plain tick");
            step(P, 1'b0, 1'b1, 1'b1, 1'b1, "R8 period tick");
            step(0, 1'b1, 1'b0, 1'b1, 1'b1, "R8 zero tick");
            run_up(1, "R7 force held");
            wr(4, 16'h000F);   // code 11 on both releases
            run_up(2, "R7 released");
            wr(4, 0);
            run_up(1, "R7 code 00");
        end
        wr(5, 3 << 6);
        wr(4, 16'h0005);       // both low, immediate
        step(1, 1'b0, 1'b0, 1'b1, 1'b1, "R8 immediate low");
        wr(4, 0);
        step(1, 1'b0, 1'b0, 1'b1, 1'b1, "R8 immediate release");

        // R9: normal and inverted polarity
        wr(2, 2); wr(3, 2);
        wr(0, 16'h001A); wr(1, 16'h0205);
        run_up(1, "R9 settle");
        hi_a = 0; hi_b = 0;
        for (int c = 0; c <= P; c++) begin
            step(c, c == 0, c == P, 1'b1, 1'b1, "R9 polarity");
            hi_a += int'(pwm_a);
            hi_b += int'(pwm_b);
            chk(pwm_a, ~pwm_b, "R9 complementary");
        end
        checks++;
        if (hi_a != 3 || hi_b != 3) begin
            errors++;
            $display("FAIL R9 high counts: got %0d/%0d expected 3/3", hi_a, hi_b);
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule